// File: doc/BRIEF.md
# Priority Pin-Allocation Crossbar

This block connects the signals of a fixed set of on-chip digital peripherals to a bank of external pins. The pins are grouped as ports of eight. Configuration bytes switch each peripheral on or off. The enabled peripherals are packed onto consecutive pins, starting at pin 0, in a fixed ranking. A pin that is not claimed by a peripheral stays a general-purpose pin and drives the value of its port latch. For pin numbering, port k covers flat pins 8k to 8k+7.

The block carries each peripheral's output data and output-enable out to its pin. It returns each pin's level to the peripheral input that owns that pin. It also presents a registered copy of the pin levels, one byte per port. The pin assignment is recomputed combinationally whenever the configuration changes. The result goes through a map register and then a registered output stage, so a configuration change cannot glitch the pins. If the enabled peripherals ask for more pins than exist, the signals that do not fit get no pin, and a sticky flag records the shortfall.

Top module: `prio_pin_xbar`

## Requirements
- R1: During reset and on the first cycle after it, `pin_out`, `pin_oe`, `port_rd` and `ovf_flag` are all zero, and every `lane_in` bit is 1.
- R2: Enabled lanes take pins 0, 1, 2, ... in lane order, with no gaps. The lane order and the enable bits are:
  - lanes 1:0, serial port A, enabled by `cfg_r0[0]`;
  - lanes 5:2, synchronous serial, enabled by `cfg_r0[1]`;
  - lanes 7:6, two-wire bus, enabled by `cfg_r0[2]`;
  - lanes 9:8, serial port B, enabled by `cfg_r0[3]`;
  - lanes 15:10, capture array;
  - lanes 16 to 30, one lane each, enabled by bits 7 to 21 of the concatenation {`cfg_r2`,`cfg_r1`,`cfg_r0`}. In rank order these are comparator 0, comparator 1, timer 0, interrupt 0, timer 1, interrupt 1, timer 2, timer 2 capture, timer 3, timer 3 capture, timer 4, timer 4 capture, clock out, converter-start 0 and converter-start 2.
- R3: When more lanes are enabled than there are pins, the lanes past the last pin get no pin and `ovf_flag` goes high. `ovf_flag` then stays high until reset.
- R4: A pin with no lane drives `pin_out` = `gpio_latch` of that pin, with `pin_oe` = 1.
- R5: A pin that carries a lane drives that lane's `lane_out` and `lane_oe`.
- R6: `lane_in` of a placed lane equals the level of its pin on `pin_in`. A lane with no pin reads 1.
- R7: `port_rd` equals `pin_in` delayed by one clock, whether or not a pin is assigned.
- R8: The capture-array field `cfg_r0[6:4]` gives n enabled lanes, starting at lane 10, for n = 0 to 6. A value of 7 gives 6 lanes.
- R9: With `cfg_r3[0]` = 0, no lane is enabled and every pin is general-purpose.
- R10: A configuration change reaches `lane_in` routing 1 clock later and reaches `pin_out`/`pin_oe` 2 clocks later. A change on `lane_out`, `lane_oe` or `gpio_latch` reaches the pins 1 clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_r0 | input | 8 | Config byte 0 (enables, capture-array count) |
| cfg_r1 | input | 8 | Config byte 1 (single-pin enables) |
| cfg_r2 | input | 8 | Config byte 2 (single-pin enables) |
| cfg_r3 | input | 8 | Config byte 3, bit 0 = crossbar on |
| gpio_latch | input | 32 | Port latch value for each pin |
| pin_in | input | 32 | Pin levels |
| lane_out | input | 31 | Peripheral output data, one bit per lane |
| lane_oe | input | 31 | Peripheral output enable, one bit per lane |
| lane_in | output | 31 | Pin level returned to each lane |
| pin_out | output | 32 | Registered pin output data |
| pin_oe | output | 32 | Registered pin output enable |
| port_rd | output | 32 | Registered pin levels, port k in bits 8k+7:8k |
| ovf_flag | output | 1 | Sticky pin-shortage flag |

## Verification
Each result falls due at a different time:
- `lane_in` follows `pin_in` in the same cycle.
- `lane_in` follows a configuration change after one edge.
- `pin_out` and `pin_oe` follow a configuration change after two edges.
- `pin_out` and `pin_oe` follow `lane_out` or `gpio_latch` after one edge.
- `port_rd` and `ovf_flag` appear after one edge.

The bench drives inputs on the falling edge and samples on the falling edge after exactly the number of rising edges given above. It also checks that the old pin value still stands one edge after a configuration write. The vector loop waits three edges before comparing, so every stage has settled.

// File: rtl/xbar_pkg.sv
// Shared constants for the priority pin crossbar.
// Assumes a fixed lane ranking of 31 peripheral signals.
package xbar_pkg;
    localparam int NLANE       = 31;   // total peripheral lanes
    localparam int PCA_BASE    = 10;   // first capture-array lane
    localparam int PCA_MAX     = 6;    // capture-array lane ceiling
    localparam int SINGLE_BASE = 16;   // first one-pin lane
    localparam int NSINGLE     = 15;   // count of one-pin lanes
    localparam int CFG_SGL_LSB = 7;    // bit of {cfg2,cfg1,cfg0} for first one-pin lane
    localparam int LANE_IW     = $clog2(NLANE);
    localparam int POS_W       = $clog2(NLANE + 1);
endpackage

// File: rtl/xbar_alloc.sv
// Combinational allocator. It turns configuration bytes into lane enables,
// packs the enabled lanes onto pins 0.. in rank order, and gives both the
// lane-to-pin and the pin-to-lane views.
// Assumes NPINS >= 1. Lanes past the last pin are left unplaced.
module xbar_alloc
    import xbar_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic [7:0]                          cfg0,
    input  logic [7:0]                          cfg1,
    input  logic [7:0]                          cfg2,
    input  logic                                xbar_on,
    output logic [NLANE-1:0]                    lane_placed,
    output logic [NLANE-1:0][POS_W-1:0]         lane_pos,
    output logic [NPINS-1:0]                    pin_hit,
    output logic [NPINS-1:0][LANE_IW-1:0]       pin_lane,
    output logic                                short_now
);
    logic [NLANE-1:0] lane_en;
    logic [23:0]      cfg_cat;
    logic [2:0]       pca_n;

    assign cfg_cat = {cfg2, cfg1, cfg0};

    // Decode the configuration bytes into one enable bit per lane.
    always_comb begin
        pca_n   = (cfg0[6:4] > 3'(PCA_MAX)) ? 3'(PCA_MAX) : cfg0[6:4];
        lane_en = '0;
        lane_en[1:0] = {2{cfg0[0]}};
        lane_en[5:2] = {4{cfg0[1]}};
        lane_en[7:6] = {2{cfg0[2]}};
        lane_en[9:8] = {2{cfg0[3]}};
        for (int k = 0; k < PCA_MAX; k++)
            lane_en[PCA_BASE + k] = (int'(pca_n) > k);
        for (int k = 0; k < NSINGLE; k++)
            lane_en[SINGLE_BASE + k] = cfg_cat[CFG_SGL_LSB + k];
        if (!xbar_on)
            lane_en = '0;
    end

    // Prefix-count the enables to get each lane's pin slot.
    always_comb begin
        int cnt;
        cnt = 0;
        for (int l = 0; l < NLANE; l++) begin
            lane_pos[l]    = POS_W'(cnt);
            lane_placed[l] = lane_en[l] && (cnt < NPINS);
            cnt            = cnt + (lane_en[l] ? 1 : 0);
        end
        short_now = (cnt > NPINS);
    end

    // Invert the map: find the lane, if any, that owns each pin.
    always_comb begin
        for (int p = 0; p < NPINS; p++) begin
            pin_hit[p]  = 1'b0;
            pin_lane[p] = '0;
            for (int l = 0; l < NLANE; l++) begin
                if (lane_placed[l] && (int'(lane_pos[l]) == p)) begin
                    pin_hit[p]  = 1'b1;
                    pin_lane[p] = LANE_IW'(l);
                end
            end
        end
    end
endmodule

// File: rtl/xbar_out_route.sv
// Registered output stage. Each pin takes its owning lane's data and enable,
// or its port latch with the enable forced on when no lane owns it.
// Assumes pin_hit/pin_lane come from a register, so the stage is glitch-free.
module xbar_out_route
    import xbar_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NPINS-1:0]              pin_hit,
    input  logic [NPINS-1:0][LANE_IW-1:0] pin_lane,
    input  logic [NLANE-1:0]              lane_out,
    input  logic [NLANE-1:0]              lane_oe,
    input  logic [NPINS-1:0]              gpio_latch,
    output logic [NPINS-1:0]              pin_out,
    output logic [NPINS-1:0]              pin_oe
);
    logic [NPINS-1:0] out_d;
    logic [NPINS-1:0] oe_d;

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        assign out_d[p] = pin_hit[p] ? lane_out[pin_lane[p]] : gpio_latch[p];
        assign oe_d[p]  = pin_hit[p] ? lane_oe[pin_lane[p]]  : 1'b1;
    end

    // Register the pin drive. Reset releases all pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_out <= '0;
            pin_oe  <= '0;
        end else begin
            pin_out <= out_d;
            pin_oe  <= oe_d;
        end
    end
endmodule

// File: rtl/xbar_in_route.sv
// Input routing. Each placed lane reads the level of its pin. An unplaced lane
// reads the inactive level 1.
// Assumes lane_pos is only meaningful where lane_placed is set.
module xbar_in_route
    import xbar_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic [NLANE-1:0]            lane_placed,
    input  logic [NLANE-1:0][POS_W-1:0] lane_pos,
    input  logic [NPINS-1:0]            pin_in,
    output logic [NLANE-1:0]            lane_in
);
    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        assign lane_in[l] = lane_placed[l] ? pin_in[lane_pos[l]] : 1'b1;
    end
endmodule

// File: rtl/prio_pin_xbar.sv
// Top of the priority pin crossbar. It registers the allocator's map, routes
// outputs through a registered stage, routes inputs from the registered map,
// keeps a sticky shortage flag and samples the pin levels for readback.
// Assumes synchronous active-low reset and a single clock.
module prio_pin_xbar
    import xbar_pkg::*;
#(
    parameter int PORT_W    = 8,
    parameter int NUM_PORTS = 4,
    localparam int NPINS    = PORT_W * NUM_PORTS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       cfg_r0,
    input  logic [7:0]       cfg_r1,
    input  logic [7:0]       cfg_r2,
    input  logic [7:0]       cfg_r3,
    input  logic [NPINS-1:0] gpio_latch,
    input  logic [NPINS-1:0] pin_in,
    input  logic [NLANE-1:0] lane_out,
    input  logic [NLANE-1:0] lane_oe,
    output logic [NLANE-1:0] lane_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe,
    output logic [NPINS-1:0] port_rd,
    output logic             ovf_flag
);
    logic [NLANE-1:0]                 nx_placed, map_placed;
    logic [NLANE-1:0][POS_W-1:0]      nx_pos,    map_pos;
    logic [NPINS-1:0]                 nx_hit,    map_hit;
    logic [NPINS-1:0][LANE_IW-1:0]    nx_lane,   map_lane;
    logic                             short_now;
    logic                             unused_cfg_bits;

    assign unused_cfg_bits = ^{cfg_r2[7:6], cfg_r3[7:1]};

    xbar_alloc #(.NPINS(NPINS)) u_alloc (
        .cfg0        (cfg_r0),
        .cfg1        (cfg_r1),
        .cfg2        (cfg_r2),
        .xbar_on     (cfg_r3[0]),
        .lane_placed (nx_placed),
        .lane_pos    (nx_pos),
        .pin_hit     (nx_hit),
        .pin_lane    (nx_lane),
        .short_now   (short_now)
    );

    // Capture the freshly computed assignment. Reset leaves every pin general-purpose.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_placed <= '0;
            map_pos    <= '0;
            map_hit    <= '0;
            map_lane   <= '0;
        end else begin
            map_placed <= nx_placed;
            map_pos    <= nx_pos;
            map_hit    <= nx_hit;
            map_lane   <= nx_lane;
        end
    end

    // Sticky shortage flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf_flag <= 1'b0;
        else if (short_now)
            ovf_flag <= 1'b1;
    end

    // Sample the pin levels for per-port readback.
    always_ff @(posedge clk) begin
        if (!rst_n)
            port_rd <= '0;
        else
            port_rd <= pin_in;
    end

    xbar_out_route #(.NPINS(NPINS)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_hit    (map_hit),
        .pin_lane   (map_lane),
        .lane_out   (lane_out),
        .lane_oe    (lane_oe),
        .gpio_latch (gpio_latch),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe)
    );

    xbar_in_route #(.NPINS(NPINS)) u_in (
        .lane_placed (map_placed),
        .lane_pos    (map_pos),
        .pin_in      (pin_in),
        .lane_in     (lane_in)
    );
endmodule

// File: rtl/prio_pin_xbar_chk.sv
// Property checker for prio_pin_xbar, attached to every instance by bind.
// Assumes the registered map signals are reachable by name in the bound scope.
module prio_pin_xbar_chk
    import xbar_pkg::*;
#(
    parameter int NPINS = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             xbar_on,
    input logic [NPINS-1:0] pin_in,
    input logic [NPINS-1:0] pin_oe,
    input logic [NPINS-1:0] port_rd,
    input logic             ovf_flag,
    input logic [NPINS-1:0] map_hit,
    input logic [NLANE-1:0] map_placed
);
    logic armed;

    // Goes high once a rising edge has passed with reset released.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else
            armed <= 1'b1;
    end

    p_pack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((map_hit + NPINS'(1)) & map_hit) == '0)
        else $error("p_pack_r2: assigned pins not contiguous from pin 0");

    p_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(map_hit) == $countones(map_placed))
        else $error("p_count_r2: pin and lane counts differ");

    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag)
        else $error("p_sticky_r3: shortage flag dropped");

    p_gpio_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> ((pin_oe | $past(map_hit)) == '1))
        else $error("p_gpio_oe_r4: free pin not driven");

    p_rdback_r7: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (port_rd == $past(pin_in)))
        else $error("p_rdback_r7: readback not one clock behind pins");

    p_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(xbar_on)) |-> (map_hit == '0))
        else $error("p_off_r9: pins assigned while crossbar off");
endmodule

bind prio_pin_xbar prio_pin_xbar_chk #(.NPINS(NPINS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xbar_on    (cfg_r3[0]),
    .pin_in     (pin_in),
    .pin_oe     (pin_oe),
    .port_rd    (port_rd),
    .ovf_flag   (ovf_flag),
    .map_hit    (map_hit),
    .map_placed (map_placed)
);

// File: tb/sim_prio_pin_xbar.sv
module sim_prio_pin_xbar;
    localparam int NL = 31;
    localparam int NP = 32;
    localparam int NP1 = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] c0 = '0, c1 = '0, c2 = '0, c3 = '0;
    logic [NP-1:0] latch = '0, pins = '0;
    logic [NL-1:0] lo = '0, loe = '0;
    logic [NL-1:0] li, li1;
    logic [NP-1:0] po, poe, prd;
    logic [NP1-1:0] po1, poe1, prd1;
    logic ovf, ovf1;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    prio_pin_xbar u0 (
        .clk(clk), .rst_n(rst_n), .cfg_r0(c0), .cfg_r1(c1), .cfg_r2(c2), .cfg_r3(c3),
        .gpio_latch(latch), .pin_in(pins), .lane_out(lo), .lane_oe(loe),
        .lane_in(li), .pin_out(po), .pin_oe(poe), .port_rd(prd), .ovf_flag(ovf)
    );

    prio_pin_xbar #(.NUM_PORTS(3)) u1 (
        .clk(clk), .rst_n(rst_n), .cfg_r0(c0), .cfg_r1(c1), .cfg_r2(c2), .cfg_r3(c3),
        .gpio_latch(latch[NP1-1:0]), .pin_in(pins[NP1-1:0]), .lane_out(lo), .lane_oe(loe),
        .lane_in(li1), .pin_out(po1), .pin_oe(poe1), .port_rd(prd1), .ovf_flag(ovf1)
    );

    // {cfg0, cfg1, cfg2, cfg3, pins claimed}
    localparam int NV = 10;
    localparam logic [39:0] VEC [NV] = '{
        {8'h01, 8'h00, 8'h00, 8'h01, 8'd2},
        {8'h07, 8'h00, 8'h00, 8'h01, 8'd8},
        {8'h02, 8'h00, 8'h00, 8'h01, 8'd4},
        {8'h70, 8'h00, 8'h00, 8'h01, 8'd6},
        {8'h50, 8'h00, 8'h00, 8'h01, 8'd5},
        {8'hFF, 8'hFF, 8'h3F, 8'h01, 8'd31},
        {8'hFF, 8'hFF, 8'h3F, 8'h00, 8'd0},
        {8'h00, 8'h00, 8'h20, 8'h01, 8'd1},
        {8'h0F, 8'h01, 8'h00, 8'h01, 8'd11},
        {8'h00, 8'h00, 8'h00, 8'h01, 8'd0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Lane enables from the bit layout in R2, R8, R9.
    function automatic logic [NL-1:0] m_en(input logic [7:0] a, b, c, d);
        logic [23:0] cat;
        logic [NL-1:0] e;
        int n;
        cat = {c, b, a};
        e = '0;
        if (!d[0]) return '0;
        e[1:0] = {2{a[0]}};
        e[5:2] = {4{a[1]}};
        e[7:6] = {2{a[2]}};
        e[9:8] = {2{a[3]}};
        n = int'(a[6:4]);
        if (n > 6) n = 6;
        for (int k = 0; k < 6; k++) e[10 + k] = (k < n);
        for (int k = 0; k < 15; k++) e[16 + k] = cat[7 + k];
        return e;
    endfunction

    function automatic int m_pos(input logic [NL-1:0] e, input int l);
        int n = 0;
        for (int j = 0; j < l; j++) n += e[j] ? 1 : 0;
        return n;
    endfunction

    function automatic logic [NL-1:0] m_lanein(input logic [NL-1:0] e, input logic [NP-1:0] pv, input int np);
        logic [NL-1:0] r = '1;
        for (int l = 0; l < NL; l++)
            if (e[l] && m_pos(e, l) < np) r[l] = pv[m_pos(e, l)];
        return r;
    endfunction

    function automatic logic [NP-1:0] m_pinout(input logic [NL-1:0] e, input logic [NL-1:0] lv, input logic [NP-1:0] lat);
        logic [NP-1:0] r = lat;
        for (int l = 0; l < NL; l++)
            if (e[l] && m_pos(e, l) < NP) r[m_pos(e, l)] = lv[l];
        return r;
    endfunction

    initial begin
        step(1);
        // R1: reset state
        step(2);
        chk("R1 pin_out", po, 32'h0);
        chk("R1 pin_oe", poe, 32'h0);
        chk("R1 port_rd", prd, 32'h0);
        chk("R1 ovf", {31'h0, ovf}, 32'h0);
        chk("R6 lane_in idle", {1'b0, li}, 32'h7FFF_FFFF);
        rst_n = 1'b1;
        step(1);
        chk("R1 pin_out first cycle", po, 32'h0);
        step(1);
        chk("R4 free pins after reset", poe, 32'hFFFF_FFFF);

        // R10: latch change lands after one edge
        latch = 32'hFFFF_FFFF;
        step(1);
        chk("R10 latch to pin 1 clk", po, 32'hFFFF_FFFF);
        // R10: config change, serial port A on pins 0..1
        c0 = 8'h01; c3 = 8'h01; lo = '0; loe = '0; pins = 32'h0000_0001;
        step(1);
        chk("R10 pins held 1 clk after cfg", po, 32'hFFFF_FFFF);
        chk("R10 lane_in 1 clk after cfg", {1'b0, li}, 32'h7FFF_FFFD);
        chk("R7 readback", prd, 32'h0000_0001);
        step(1);
        chk("R10 pin_out 2 clk after cfg", po, 32'hFFFF_FFFC);
        chk("R5 pin_oe from lane", poe, 32'hFFFF_FFFC);
        pins = 32'h1234_5678;
        step(1);
        chk("R7 readback of assigned pins", prd, 32'h1234_5678);

        // Vector table: R2 R4 R5 R6 R8 R9
        for (int i = 0; i < NV; i++) begin
            logic [NL-1:0] e;
            logic [NP-1:0] mask;
            c0 = VEC[i][39:32]; c1 = VEC[i][31:24]; c2 = VEC[i][23:16]; c3 = VEC[i][15:8];
            mask = NP'((33'h1 << VEC[i][7:0]) - 33'h1);
            e = m_en(c0, c1, c2, c3);
            lo = '1; loe = '1; latch = '0; pins = '0;
            step(3);
            chk($sformatf("R2 packing v%0d", i), po, mask);
            chk($sformatf("R5 oe v%0d", i), poe, 32'hFFFF_FFFF);
            chk($sformatf("R6 lane_in v%0d", i), {1'b0, li}, {1'b0, ~e});
            pins = 32'hC3A5_5A3C;
            step(1);
            chk($sformatf("R2 order lane_in v%0d", i), {1'b0, li}, {1'b0, m_lanein(e, pins, NP)});
            lo = 31'h2AF0_1C35; loe = 31'h5555_0F0F; latch = 32'hFFFF_0000;
            step(1);
            chk($sformatf("R4 R5 pin_out v%0d", i), po, m_pinout(e, lo, latch));
            chk($sformatf("R5 pin_oe v%0d", i), poe, m_pinout(e, loe, 32'hFFFF_FFFF));
        end

        // R3: 24-pin instance runs short
        c0 = 8'hFF; c1 = 8'hFF; c2 = 8'h3F; c3 = 8'h01; pins = '0; lo = '1; latch = '0;
        step(3);
        chk("R3 ovf set on short", {31'h0, ovf1}, 32'h1);
        chk("R3 no ovf when fitting", {31'h0, ovf}, 32'h0);
        chk("R3 unfitted lanes read 1", {1'b0, li1}, 32'h7F00_0000);
        chk("R3 all 24 pins assigned", {8'h0, po1}, 32'h00FF_FFFF);
        c3 = 8'h00;
        step(3);
        chk("R3 ovf sticky", {31'h0, ovf1}, 32'h1);
        chk("R9 off frees pins", {8'h0, po1}, 32'h0);
        rst_n = 1'b0;
        step(1);
        rst_n = 1'b1;
        step(1);
        chk("R3 ovf cleared by reset", {31'h0, ovf1}, 32'h0);

        // R8: count field 3 gives lanes 10..12
        c0 = 8'h30; c1 = 8'h00; c2 = 8'h00; c3 = 8'h01;
        step(3);
        chk("R8 capture count 3", po, 32'h0000_0007);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule